// File: doc/BRIEF.md
# Three-Level Interrupt Gating Controller

This block collects interrupt events from sixteen sources inside a card host controller and turns them into one level-sensitive request line. Every source is governed by three bits of its own: a pending bit that records that the event happened, a capture enable that decides whether the event is recorded at all, and a line enable that decides whether a recorded event may drive the request line. Event inputs are single-cycle pulses from the surrounding logic.

Software reaches the three per-source registers through a small word interface with a write strobe, a two-bit address and a combinational read port. Pending bits are cleared by writing ones to them. The request line is registered, so it follows a change of pending bits or enables one clock later. A source whose capture enable is off neither records events nor contributes to the request line, whatever its line enable holds.

Top module: `irqg_ctrl`

## Requirements
- R1: After reset the pending, capture-enable and line-enable registers all read 0 and `irq_o` is 0.
- R2: An event pulse on a source whose capture enable is 1 sets that source's pending bit at the clock edge that samples the pulse.
- R3: An event pulse on a source whose capture enable is 0 leaves its pending bit unchanged.
- R4: `irq_o` is 1 in the cycle after any source has pending, capture enable and line enable all at 1, and is 0 in the cycle after no source has all three.
- R5: A source whose capture enable is 0 never causes `irq_o`, even when its pending bit and line enable are both 1; its pending bit is kept and drives the line again once capture is re-enabled.
- R6: Clearing the line enable of the only requesting source drops `irq_o` one cycle after the write takes effect.
- R7: Writing to the pending register (address 0) clears each bit written as 1; bits written as 0 keep their value, and such a write never sets a bit.
- R8: When an event is captured in the same cycle as a write that clears that bit, the bit ends up set.
- R9: A pending bit cleared while its line enable is 0 stays 0 when the line enable is later set, and `irq_o` stays 0 until a new event arrives.
- R10: Address 0 reads the pending bits, address 1 the capture enables, address 2 the line enables; address 3 reads 0 and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 16 | Single-cycle event pulses, one per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address (0 pending, 1 capture enable, 2 line enable) |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 2 | Read address, same map as writes |
| rd_data_o | output | 16 | Combinational read data |
| irq_o | output | 1 | Registered level interrupt request |

## Verification
The bench targets the cases where the three gates interact: a pending bit left set while capture is turned off, which a design that gated only the line enable would still signal, and a bit cleared while masked, which a design that latched the request separately would re-raise on unmask. It collides an event with a write-one-to-clear of the same bit, where a clear-first design loses the event, and checks that zero bits in a clear write and writes to the unused address touch nothing. It also samples `irq_o` in the cycle before and the cycle after each change so that a combinational or two-stage request path shows up as an off-by-one.

// File: rtl/irqg_pkg.sv
package irqg_pkg;

  localparam int unsigned IRQG_AW = 2;

  typedef enum logic [IRQG_AW-1:0] {
    REG_PEND   = 2'd0,
    REG_CAP_EN = 2'd1,
    REG_LINE_EN = 2'd2,
    REG_UNUSED = 2'd3
  } irqg_reg_e;

endpackage

// File: rtl/irqg_en_reg.sv
module irqg_en_reg #(
  parameter int unsigned          N   = 16,
  parameter irqg_pkg::irqg_reg_e  SEL = irqg_pkg::REG_CAP_EN
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [irqg_pkg::IRQG_AW-1:0]  wr_addr,
  input  logic [N-1:0]                  wr_data,
  output logic [N-1:0]                  q
);

  logic hit;
  assign hit = wr_en && (wr_addr == SEL);

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (hit) q <= wr_data;
  end

  a_r10_en_write: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (q == $past(wr_data)));

  a_r10_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(q));

endmodule

// File: rtl/irqg_pend_bank.sv
module irqg_pend_bank #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] cap_en,
  input  logic         clr_stb,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] pend
);

  // Set wins over clear: an event in the clear cycle is not lost.
  function automatic logic next_bit(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  logic [N-1:0] set_hit;
  logic [N-1:0] clr_hit;

  assign set_hit = evt & cap_en;
  assign clr_hit = clr_stb ? clr_mask : '0;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) pend[i] <= 1'b0;
      else        pend[i] <= next_bit(pend[i], set_hit[i], clr_hit[i]);
    end
  end

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_hit) |=> ((pend & $past(set_hit)) == $past(set_hit)));

  a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(evt & cap_en)) == '0));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((pend & $past(clr_mask & ~(evt & cap_en))) == '0));

  a_r7_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((pend & $past(~clr_mask)) == ($past(pend | (evt & cap_en)) & $past(~clr_mask))));

endmodule

// File: rtl/irqg_req_out.sv
module irqg_req_out #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pend,
  input  logic [N-1:0] cap_en,
  input  logic [N-1:0] line_en,
  output logic         irq
);

  function automatic logic any_live(input logic [N-1:0] p, input logic [N-1:0] c,
                                    input logic [N-1:0] l);
    return |(p & c & l);
  endfunction

  logic live;
  assign live = any_live(pend, cap_en, line_en);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= live;
  end

  a_r4_raise: assert property (@(posedge clk) disable iff (!rst_n)
    live |=> irq);

  a_r4_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> !irq);

  a_r5_cap_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & cap_en) == '0) |=> !irq);

endmodule

// File: rtl/irqg_ctrl.sv
module irqg_ctrl #(
  parameter int unsigned N = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N-1:0]                  evt_i,
  input  logic                          wr_en_i,
  input  logic [irqg_pkg::IRQG_AW-1:0]  wr_addr_i,
  input  logic [N-1:0]                  wr_data_i,
  input  logic [irqg_pkg::IRQG_AW-1:0]  rd_addr_i,
  output logic [N-1:0]                  rd_data_o,
  output logic                          irq_o
);
  import irqg_pkg::*;

  logic [N-1:0] cap_en;
  logic [N-1:0] line_en;
  logic [N-1:0] pend;
  logic         clr_stb;

  assign clr_stb = wr_en_i && (wr_addr_i == REG_PEND);

  irqg_en_reg #(.N(N), .SEL(REG_CAP_EN)) u_cap_en (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .q(cap_en)
  );

  irqg_en_reg #(.N(N), .SEL(REG_LINE_EN)) u_line_en (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .q(line_en)
  );

  irqg_pend_bank #(.N(N)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt(evt_i), .cap_en(cap_en),
    .clr_stb(clr_stb), .clr_mask(wr_data_i), .pend(pend)
  );

  irqg_req_out #(.N(N)) u_req (
    .clk(clk), .rst_n(rst_n), .pend(pend), .cap_en(cap_en),
    .line_en(line_en), .irq(irq_o)
  );

  always_comb begin
    case (rd_addr_i)
      REG_PEND:    rd_data_o = pend;
      REG_CAP_EN:  rd_data_o = cap_en;
      REG_LINE_EN: rd_data_o = line_en;
      default:     rd_data_o = '0;
    endcase
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!irq_o && pend == '0 && cap_en == '0 && line_en == '0));

  a_r10_unused_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i == REG_UNUSED) |-> (rd_data_o == '0));

endmodule

// File: tb/test_irqg_ctrl.sv
module test_irqg_ctrl;

  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] evt_i = '0;
  logic         wr_en_i = 1'b0;
  logic [1:0]   wr_addr_i = '0;
  logic [N-1:0] wr_data_i = '0;
  logic [1:0]   rd_addr_i = '0;
  logic [N-1:0] rd_data_o;
  logic         irq_o;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  irqg_ctrl #(.N(N)) i_irqg_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk);
    evt_i = m;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    rd_addr_i = a;
    #1;
    d = rd_data_o;
  endtask

  task automatic chk_reg(input string req, input logic [1:0] a, input logic [N-1:0] exp);
    logic [N-1:0] v;
    rd(a, v);
    chk(req, 32'(v), 32'(exp));
  endtask

  // address map used below: 0 pending (W1C), 1 capture enable, 2 line enable, 3 unused
  task automatic t_reset();
    chk_reg("R1 pending", 2'd0, '0);
    chk_reg("R1 cap_en", 2'd1, '0);
    chk_reg("R1 line_en", 2'd2, '0);
    chk("R1 irq", 32'(irq_o), 0);
  endtask

  task automatic t_map();
    wr(2'd1, 16'h00F0);
    chk_reg("R10 cap_en readback", 2'd1, 16'h00F0);
    wr(2'd2, 16'h0F0F);
    chk_reg("R10 line_en readback", 2'd2, 16'h0F0F);
    wr(2'd3, 16'hFFFF);
    chk_reg("R10 unused reads 0", 2'd3, '0);
    chk_reg("R10 unused write leaves cap_en", 2'd1, 16'h00F0);
    chk_reg("R10 unused write leaves line_en", 2'd2, 16'h0F0F);
    wr(2'd0, 16'hFFFF);
    chk_reg("R7 clear write never sets", 2'd0, '0);
  endtask

  task automatic t_capture_and_raise();
    pulse(16'h0011);
    chk_reg("R2/R3 capture gated", 2'd0, 16'h0010);
    @(negedge clk);
    chk("R4 no line enable no irq", 32'(irq_o), 0);
    wr(2'd2, 16'h0010);
    chk("R4 irq latency (still low)", 32'(irq_o), 0);
    @(negedge clk);
    chk("R4 irq raised", 32'(irq_o), 1);
  endtask

  task automatic t_mask();
    wr(2'd2, 16'h0000);
    chk("R6 irq held one cycle", 32'(irq_o), 1);
    @(negedge clk);
    chk("R6 irq dropped", 32'(irq_o), 0);
    chk_reg("R6 pending kept", 2'd0, 16'h0010);
  endtask

  task automatic t_clear_while_masked();
    wr(2'd0, 16'h0010);
    chk_reg("R9 cleared", 2'd0, '0);
    wr(2'd2, 16'h0010);
    @(negedge clk);
    @(negedge clk);
    chk("R9 no irq after unmask", 32'(irq_o), 0);
    chk_reg("R9 pending stays 0", 2'd0, '0);
  endtask

  task automatic t_cap_gate();
    pulse(16'h0010);
    @(negedge clk);
    chk("R4 new event raises irq", 32'(irq_o), 1);
    wr(2'd1, 16'h0000);
    @(negedge clk);
    chk("R5 capture off suppresses irq", 32'(irq_o), 0);
    chk_reg("R5 pending kept", 2'd0, 16'h0010);
    pulse(16'h0020);
    chk_reg("R3 no capture when disabled", 2'd0, 16'h0010);
    wr(2'd1, 16'h00F0);
    @(negedge clk);
    chk("R5 irq returns on re-enable", 32'(irq_o), 1);
    wr(2'd0, 16'hFFFF);
    @(negedge clk);
    chk("R4 irq drops after clear", 32'(irq_o), 0);
  endtask

  task automatic t_w1c();
    pulse(16'h0070);
    chk_reg("R2 three bits", 2'd0, 16'h0070);
    wr(2'd0, 16'h0020);
    chk_reg("R7 partial clear", 2'd0, 16'h0050);
    wr(2'd0, 16'h0000);
    chk_reg("R7 zero write no effect", 2'd0, 16'h0050);
  endtask

  task automatic t_collision();
    @(negedge clk);
    evt_i = 16'h0010;
    wr_en_i = 1'b1; wr_addr_i = 2'd0; wr_data_i = 16'h0050;
    @(negedge clk);
    evt_i = '0; wr_en_i = 1'b0;
    chk_reg("R8 event beats clear", 2'd0, 16'h0010);
    wr(2'd0, 16'h0010);
    chk_reg("R8 cleared afterwards", 2'd0, '0);
  endtask

  task automatic t_top_bit();
    wr(2'd1, 16'hFFFF);
    wr(2'd2, 16'h8000);
    pulse(16'h8001);
    chk_reg("R2 top and bottom bit", 2'd0, 16'h8001);
    @(negedge clk);
    chk("R4 top source raises irq", 32'(irq_o), 1);
    wr(2'd0, 16'h8000);
    @(negedge clk);
    chk("R4 bottom source masked, irq drops", 32'(irq_o), 0);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_capture_and_raise();
    t_mask();
    t_clear_while_masked();
    t_cap_gate();
    t_w1c();
    t_collision();
    t_top_bit();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule